// File: doc/BRIEF.md
# Per-Flow Packet and Byte Counter Table

This block keeps one byte counter (48 bits) and one packet counter (40 bits) for each entry of a flow table. A packet-event port delivers, for each forwarded packet, the flow index, the packet length and a count-enable flag that belongs to that flow. When the global enable is on and the flow's flag is set, the entry's byte counter grows by the packet length and its packet counter grows by one. Both counters wrap modulo their width.

Software reaches the counters through a small word-addressed register port. It writes an entry index together with a start flag into the command register, polls the start flag until it drops, and then reads three result registers that hold the two counters packed together. Every read finishes a fixed number of cycles after it starts, so a polling loop with a bounded timeout is enough. An optional read-clear mode zeroes the entry as the read completes. A packet that hits the same entry in the completing cycle is not lost: it is added to the cleared value.

After reset the counter storage is zeroed by a sweep that covers one entry per clock. Packet events are ignored during the sweep. A read started during the sweep stays busy and completes once the sweep has ended.

Top module: `flow_stat_table`

## Requirements
- R1: After a synchronous reset, every register reads zero: configuration, command (including busy) and all three result registers.
- R2: After reset a sweep takes one cycle per entry. During the sweep packet events are not counted, and a read started during the sweep stays busy until the sweep ends. It then returns the zeroed entry.
- R3: The command register (word 1) holds the entry index in bits 13:0 and start/busy in bit 16. A write stores the index, and starts a read only if bit 16 is 1. A read-back returns the stored index and the current busy flag.
- R4: A started read completes on the fourth rising clock edge after the edge that accepts the command write. Busy clears on that same edge and the result registers are loaded on it.
- R5: Result word 2 holds byte count bits 31:0. Result word 3 holds byte bits 47:32 in its bits 15:0 and packet bits 15:0 in its bits 31:16. Result word 4 holds packet bits 39:16 in its bits 23:0, and its bits 31:24 read as zero. The result registers change only when a read completes.
- R6: An event adds its length to the byte counter and one to the packet counter only when the configuration enable (word 0, bit 0) is 1 and the event's count-enable flag is 1. Back-to-back events to the same entry all accumulate.
- R7: The counters of an entry that is never hit are not changed by events to other entries.
- R8: With read-clear (word 0, bit 1) set, a completed read zeroes that entry. With it clear, a read leaves the counters intact.
- R9: An event to the entry being read, presented in the cycle the read completes, is excluded from the returned value. With read-clear set, that event lands on the cleared entry.
- R10: A write to the command register while a read is busy is ignored: neither the index nor the running read changes.
- R11: The register map is word 0 configuration (bits 1:0 only), word 1 command, words 2 to 4 results. Writes to the result words have no effect, and unmapped words read zero. Read data is registered and reflects the word addressed in the previous cycle.
- R12: An index at or above the table size is out of range. Events with such an index are dropped, and a read of such an index returns zero without touching any entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | A packet event is presented this cycle |
| ev_flow | input | 14 | Flow table index of the packet |
| ev_len | input | LEN_W | Packet length in bytes |
| ev_count_en | input | 1 | Per-flow count-enable flag carried with the event |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the word addressed in the previous cycle |

## Verification
The checks assume that software respects the busy handshake. They assume it does not count on command writes made during a busy period, and that it reads the result words only after busy has dropped. The bench always polls busy to zero before reading results. The only command write it makes during a busy period is the deliberate one that tests the ignore rule. The checks also assume that event lengths fit LEN_W and that a packet event is a single-cycle strobe with stable fields. The bench drives all inputs on the falling edge. It sends events outside the completing cycle, except in the one scenario that aims an event at exactly that edge.

// File: rtl/flow_stat_pkg.sv
package flow_stat_pkg;
  localparam int BYTE_W    = 48;
  localparam int PKT_W     = 40;
  localparam int REG_W     = 32;
  localparam int FLOW_W    = 14;
  localparam int START_BIT = 16;
  localparam int RD_LAT    = 4;

  localparam logic [2:0] WA_CFG  = 3'd0;
  localparam logic [2:0] WA_CMD  = 3'd1;
  localparam logic [2:0] WA_RES0 = 3'd2;
  localparam logic [2:0] WA_RES1 = 3'd3;
  localparam logic [2:0] WA_RES2 = 3'd4;

  typedef struct packed {
    logic [BYTE_W-1:0] bytes;
    logic [PKT_W-1:0]  pkts;
  } flow_cnt_t;
endpackage

// File: rtl/fst_store.sv
module fst_store
  import flow_stat_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int LEN_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_go,
  input  logic [IDX_W-1:0] ev_idx,
  input  logic [LEN_W-1:0] ev_len,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_take,
  input  logic             rd_clear,
  output flow_cnt_t        rd_data,
  output logic             sweeping
);
  flow_cnt_t          mem [ENTRIES];
  logic [ENTRIES-1:0] stale;
  logic [IDX_W-1:0]   sw_idx;
  flow_cnt_t          ev_base;
  flow_cnt_t          ev_next;
  logic               clr_now;

  assign clr_now = rd_take & rd_clear;

  // an entry marked stale, or being cleared this cycle, counts from zero
  always_comb begin
    if (stale[ev_idx] || (clr_now && (rd_idx == ev_idx)))
      ev_base = '0;
    else
      ev_base = mem[ev_idx];
    ev_next.bytes = ev_base.bytes + BYTE_W'(ev_len);
    ev_next.pkts  = ev_base.pkts + PKT_W'(1);
    rd_data       = stale[rd_idx] ? '0 : mem[rd_idx];
  end

  // single write port, no reset on the array
  always_ff @(posedge clk) begin
    if (sweeping)
      mem[sw_idx] <= '0;
    else if (ev_go)
      mem[ev_idx] <= ev_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sweeping <= 1'b1;
      sw_idx   <= '0;
    end else if (sweeping) begin
      sw_idx <= sw_idx + 1'b1;
      if (sw_idx == IDX_W'(ENTRIES - 1))
        sweeping <= 1'b0;
    end
  end

  // a clear only marks the entry; a same-entry event (later statement) wins
  always_ff @(posedge clk) begin
    if (rst) begin
      stale <= '0;
    end else begin
      if (clr_now)
        stale[rd_idx] <= 1'b1;
      if (ev_go)
        stale[ev_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/fst_rd_seq.sv
module fst_rd_seq
  import flow_stat_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic hold,
  output logic busy,
  output logic take
);
  localparam int CNT_W = $clog2(RD_LAT);

  logic [CNT_W-1:0] cnt;

  assign take = busy & ~hold & (cnt == CNT_W'(RD_LAT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy && !hold) begin
      cnt <= cnt + 1'b1;
      if (take)
        busy <= 1'b0;
    end
  end
endmodule

// File: rtl/fst_regs.sv
module fst_regs
  import flow_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              busy,
  input  logic              take,
  input  flow_cnt_t         rd_data,
  output logic              cfg_en,
  output logic              cfg_rdclr,
  output logic [FLOW_W-1:0] cmd_addr,
  output logic              start,
  output logic [REG_W-1:0]  res0,
  output logic [REG_W-1:0]  res1,
  output logic [REG_W-1:0]  res2
);
  localparam int HI_B = BYTE_W - REG_W;
  localparam int LO_P = REG_W - HI_B;
  localparam int HI_P = PKT_W - LO_P;

  logic cmd_wr;
  logic unused_wbits;

  assign cmd_wr       = reg_we && (reg_addr == WA_CMD) && !busy;
  assign start        = cmd_wr && reg_wdata[START_BIT];
  assign unused_wbits = ^{reg_wdata[REG_W-1:START_BIT+1], reg_wdata[START_BIT-1:FLOW_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en    <= 1'b0;
      cfg_rdclr <= 1'b0;
      cmd_addr  <= '0;
    end else begin
      if (reg_we && (reg_addr == WA_CFG)) begin
        cfg_en    <= reg_wdata[0];
        cfg_rdclr <= reg_wdata[1];
      end
      if (cmd_wr)
        cmd_addr <= reg_wdata[FLOW_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res0 <= '0;
      res1 <= '0;
      res2 <= '0;
    end else if (take) begin
      res0 <= rd_data.bytes[REG_W-1:0];
      res1 <= {rd_data.pkts[LO_P-1:0], rd_data.bytes[BYTE_W-1:REG_W]};
      res2 <= {{(REG_W-HI_P){1'b0}}, rd_data.pkts[PKT_W-1:LO_P]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        WA_CFG:  reg_rdata <= {{(REG_W-2){1'b0}}, cfg_rdclr, cfg_en};
        WA_CMD:  reg_rdata <= {{(REG_W-START_BIT-1){1'b0}}, busy,
                               {(START_BIT-FLOW_W){1'b0}}, cmd_addr};
        WA_RES0: reg_rdata <= res0;
        WA_RES1: reg_rdata <= res1;
        WA_RES2: reg_rdata <= res2;
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/flow_stat_table.sv
module flow_stat_table
  import flow_stat_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int LEN_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [FLOW_W-1:0] ev_flow,
  input  logic [LEN_W-1:0]  ev_len,
  input  logic              ev_count_en,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic              cfg_en, cfg_rdclr, start, busy, take, sweeping;
  logic              ev_in_range, rd_in_range, ev_go, st_take;
  logic [FLOW_W-1:0] cmd_addr;
  logic [REG_W-1:0]  res0, res1, res2;
  flow_cnt_t         st_data, rd_cnt;

  generate
    if (IDX_W < FLOW_W) begin : g_part
      assign ev_in_range = (ev_flow[FLOW_W-1:IDX_W] == '0);
      assign rd_in_range = (cmd_addr[FLOW_W-1:IDX_W] == '0);
    end else begin : g_full
      assign ev_in_range = 1'b1;
      assign rd_in_range = 1'b1;
    end
  endgenerate

  assign ev_go   = ev_valid & ev_count_en & cfg_en & ev_in_range & ~sweeping;
  assign st_take = take & rd_in_range;
  assign rd_cnt  = rd_in_range ? st_data : '0;

  fst_store #(.ENTRIES(ENTRIES), .LEN_W(LEN_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .ev_go    (ev_go),
    .ev_idx   (ev_flow[IDX_W-1:0]),
    .ev_len   (ev_len),
    .rd_idx   (cmd_addr[IDX_W-1:0]),
    .rd_take  (st_take),
    .rd_clear (cfg_rdclr),
    .rd_data  (st_data),
    .sweeping (sweeping)
  );

  fst_rd_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .hold  (sweeping),
    .busy  (busy),
    .take  (take)
  );

  fst_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .take      (take),
    .rd_data   (rd_cnt),
    .cfg_en    (cfg_en),
    .cfg_rdclr (cfg_rdclr),
    .cmd_addr  (cmd_addr),
    .start     (start),
    .res0      (res0),
    .res1      (res1),
    .res2      (res2)
  );
endmodule

// File: rtl/flow_stat_table_chk.sv
module flow_stat_table_chk
  import flow_stat_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              take,
  input logic              sweeping,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [FLOW_W-1:0] cmd_addr,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [REG_W-1:0]  res0,
  input logic [REG_W-1:0]  res1,
  input logic [REG_W-1:0]  res2
);
  logic [3:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy)
      run_cnt <= '0;
    else if (!sweeping && run_cnt != 4'hF)
      run_cnt <= run_cnt + 1'b1;
  end

  // R4: a read never runs longer than the fixed latency once unblocked
  p_bounded_read_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !sweeping) |-> (run_cnt < 4'(RD_LAT)));

  // R4: busy drops on the completing edge
  p_done_clears_busy_r4: assert property (@(posedge clk) disable iff (rst)
    take |=> !busy);

  // R2: no read completes during the sweep
  p_sweep_blocks_read_r2: assert property (@(posedge clk) disable iff (rst)
    sweeping |-> !take);

  // R10: command writes during a busy read leave the index unchanged
  p_cmd_locked_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_we && reg_addr == WA_CMD) |=> $stable(cmd_addr));

  // R5: results change only on a completed read
  p_results_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable({res0, res1, res2}));

  // R5: top byte of the last result word is always zero
  p_res2_top_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == WA_RES2) |=> (reg_rdata[31:24] == 8'h00));
endmodule

bind flow_stat_table flow_stat_table_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .take      (take),
  .sweeping  (sweeping),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .cmd_addr  (cmd_addr),
  .reg_rdata (reg_rdata),
  .res0      (res0),
  .res1      (res1),
  .res2      (res2)
);

// File: tb/flow_stat_table_tb.sv
module flow_stat_table_tb;
  localparam int N_ENT = 256;
  localparam logic [2:0] A_CFG = 3'd0, A_CMD = 3'd1, A_R0 = 3'd2, A_R1 = 3'd3, A_R2 = 3'd4;
  localparam logic [31:0] GO = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic [13:0] ev_flow = '0;
  logic [15:0] ev_len = '0;
  logic        ev_count_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flow_stat_table #(.ENTRIES(N_ENT), .LEN_W(16)) u_dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_flow(ev_flow), .ev_len(ev_len),
    .ev_count_en(ev_count_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic send(input int flow, input int len, input bit en, input int n);
    @(negedge clk);
    ev_valid = 1'b1; ev_flow = 14'(flow); ev_len = 16'(len); ev_count_en = en;
    repeat (n) @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic get_res(output logic [47:0] b, output logic [39:0] p, output logic [31:0] top);
    logic [31:0] r0, r1, r2;
    rd(A_R0, r0); rd(A_R1, r1); rd(A_R2, r2);
    b = {r1[15:0], r0};
    p = {r2[23:0], r1[31:16]};
    top = r2;
  endtask

  task automatic wait_idle(input string req, input int limit);
    reg_addr = A_CMD;
    @(negedge clk);
    for (int i = 0; i < limit && reg_rdata[16]; i++) @(negedge clk);
    chk(req, reg_rdata[16], 1'b0);
  endtask

  task automatic do_read(input int idx, input int limit, output logic [47:0] b, output logic [39:0] p);
    logic [31:0] top;
    wr(A_CMD, GO | 32'(idx));
    wait_idle("R4 busy drops", limit);
    get_res(b, p, top);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CFG, d);  chk("R1 cfg", d, 0);
    rd(A_CMD, d);  chk("R1 cmd", d, 0);
    rd(A_R0, d);   chk("R1 res0", d, 0);
    rd(A_R1, d);   chk("R1 res1", d, 0);
    rd(A_R2, d);   chk("R1 res2", d, 0);
  endtask

  task automatic t_sweep();
    logic [31:0] d;
    logic [47:0] b;
    logic [39:0] p;
    wr(A_CFG, 32'h1);
    send(5, 100, 1'b1, 1);
    wr(A_CMD, GO | 32'd5);
    repeat (10) @(negedge clk);
    rd(A_CMD, d);
    chk("R2 busy held during sweep", d, GO | 32'd5);
    wait_idle("R2 read ends after sweep", 2 * N_ENT);
    get_res(b, p, d);
    chk("R2 bytes zero", b, 0);
    chk("R2 pkts zero", p, 0);
  endtask

  task automatic t_cmd_field();
    logic [31:0] d;
    wr(A_CMD, 32'h0000_22A5);
    rd(A_CMD, d);
    chk("R3 index stored, no start", d, 32'h0000_22A5);
  endtask

  task automatic t_count();
    logic [47:0] b;
    logic [39:0] p;
    wr(A_CFG, 32'h1);
    send(3, 64, 1'b1, 1);
    send(3, 1500, 1'b1, 1);
    send(3, 9000, 1'b1, 1);
    send(3, 777, 1'b0, 1);
    send(4, 10, 1'b1, 1);
    send(6, 20, 1'b1, 3);
    do_read(3, 20, b, p);
    chk("R6 bytes flow3", b, 10564);
    chk("R6 pkts flow3", p, 3);
    do_read(6, 20, b, p);
    chk("R6 back-to-back bytes", b, 60);
    chk("R6 back-to-back pkts", p, 3);
    do_read(8, 20, b, p);
    chk("R7 untouched entry", {b, 16'(p)}, 0);
  endtask

  task automatic t_latency();
    logic [47:0] b;
    logic [39:0] p;
    logic [31:0] top;
    wr(A_CMD, GO | 32'd3);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R4 busy during read", reg_rdata, GO | 32'd3);
    end
    @(negedge clk);
    chk("R4 busy cleared on 4th edge", reg_rdata, 32'd3);
    get_res(b, p, top);
    chk("R8 no-clear retains bytes", b, 10564);
    chk("R8 no-clear retains pkts", p, 3);
  endtask

  task automatic t_ignore();
    logic [47:0] b;
    logic [39:0] p;
    logic [31:0] d, top;
    wr(A_CMD, GO | 32'd3);
    wr(A_CMD, GO | 32'd4);
    wait_idle("R10 read finishes", 20);
    get_res(b, p, top);
    chk("R10 result from first index", b, 10564);
    rd(A_CMD, d);
    chk("R10 index unchanged", d, 32'd3);
  endtask

  task automatic t_disable();
    logic [47:0] b;
    logic [39:0] p;
    wr(A_CFG, 32'h0);
    send(3, 5, 1'b1, 2);
    wr(A_CFG, 32'h1);
    do_read(3, 20, b, p);
    chk("R6 global enable off", b, 10564);
  endtask

  task automatic t_clear();
    logic [47:0] b;
    logic [39:0] p;
    wr(A_CFG, 32'h3);
    do_read(4, 20, b, p);
    chk("R8 first read bytes", b, 10);
    chk("R8 first read pkts", p, 1);
    do_read(4, 20, b, p);
    chk("R8 cleared entry", {b, 16'(p)}, 0);
  endtask

  task automatic t_collide();
    logic [47:0] b;
    logic [39:0] p;
    logic [31:0] top;
    wr(A_CFG, 32'h3);
    send(9, 50, 1'b1, 2);
    wr(A_CMD, GO | 32'd9);
    repeat (3) @(negedge clk);
    ev_valid = 1'b1; ev_flow = 14'd9; ev_len = 16'd30; ev_count_en = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
    wait_idle("R9 read finishes", 20);
    get_res(b, p, top);
    chk("R9 event excluded bytes", b, 100);
    chk("R9 event excluded pkts", p, 2);
    do_read(9, 20, b, p);
    chk("R9 event kept after clear bytes", b, 30);
    chk("R9 event kept after clear pkts", p, 1);
  endtask

  task automatic t_range();
    logic [47:0] b;
    logic [39:0] p;
    wr(A_CFG, 32'h1);
    send(N_ENT + 44, 70, 1'b1, 1);
    do_read(N_ENT + 44, 20, b, p);
    chk("R12 out-of-range read zero", {b, 16'(p)}, 0);
    do_read(44, 20, b, p);
    chk("R12 no aliasing", {b, 16'(p)}, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(A_R0, 32'hFFFF_FFFF);
    rd(A_R0, d);
    chk("R11 result not writable", d, 32'd0);
    rd(3'd7, d);
    chk("R11 unmapped word", d, 0);
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, d);
    chk("R11 cfg width", d, 32'h3);
    wr(A_CFG, 32'h1);
  endtask

  task automatic t_pack();
    logic [47:0] b;
    logic [39:0] p;
    logic [31:0] top;
    send(7, 65535, 1'b1, 65538);
    wr(A_CMD, GO | 32'd7);
    wait_idle("R5 read finishes", 20);
    get_res(b, p, top);
    chk("R5 byte count 33 bits", b, 48'h1_0000_FFFE);
    chk("R5 pkt count 17 bits", p, 40'h1_0002);
    chk("R5 res2 upper zero", top[31:24], 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sweep();
    t_cmd_field();
    t_count();
    t_latency();
    t_ignore();
    t_disable();
    t_clear();
    t_collide();
    t_range();
    t_map();
    t_pack();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule